// File: doc/BRIEF.md
# Data Pointer Select and Control Unit

This block holds the data-memory pointers that a load unit uses to form its source address: two direct pointers, a base register and a narrower offset register. Base plus offset makes up the frame pointer. A 16-bit control word sets the access width of each of the three pointers and chooses which one is the active load source. All five registers sit behind one simple register port. Writes through that port are synchronous, and reads are combinational.

Any pointer write also moves the source choice to that pointer. The block outputs the chosen source, its effective address and its word/byte mode. It also tracks whether a source has been activated since reset. Before that happens, the select field reads zero but no source counts as active. A load request made in that window raises an error flag.

Top module: `dptr_select_unit`

## Requirements
- R1: After reset the control word reads 0x001C, all four pointer registers read zero, srcActive is low and srcIdx is 0.
- R2: Control word bits 15:5 always read zero, and writes to them have no effect on any output.
- R3: Control bit 2 sets the mode of direct pointer 0, bit 3 sets the mode of direct pointer 1 and bit 4 sets the mode of the frame pointer. srcWordMode shows the bit of the active source, where 1 means word mode and 0 means byte mode.
- R4: Select bits 1:0 choose the source. 00 chooses pointer 0 (srcIdx 0), 01 chooses pointer 1 (srcIdx 1), and both 10 and 11 choose the frame pointer (srcIdx 2). srcAddr carries the address of the chosen source.
- R5: A write to pointer 0 sets the select bits to 00, and a write to pointer 1 sets them to 01. A write to base or offset sets them to 10. The mode bits stay unchanged, and the new select value is visible one clock after the write.
- R6: srcActive is low from reset until the first write to the control word or to any pointer register. It then stays high until the next reset.
- R7: loadErr is high exactly when loadReq is high while srcActive is low.
- R8: The frame address equals base plus the zero-extended offset, modulo 2^16.
- R9: The register map is: address 0 is the control word, 1 is pointer 0, 2 is pointer 1, 3 is base and 4 is offset. Addresses 5 to 7 read zero, and writes to them change nothing.
- R10: Pointer 0, pointer 1 and base store all 16 written bits. Offset stores only the low 8 bits and reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for reads and writes |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Combinational read data for regAddr |
| loadReq | input | 1 | Load request from the execution side |
| srcIdx | output | 2 | Active source: 0 pointer 0, 1 pointer 1, 2 frame |
| srcAddr | output | 16 | Effective address of the active source |
| srcWordMode | output | 1 | 1 when the active source is in word mode |
| srcActive | output | 1 | A source has been activated since reset |
| loadErr | output | 1 | Load requested with no active source |

## Verification
The bench uses the default parameters: 16-bit pointers, an 8-bit offset and a 3-bit register address. With these, base values near 0xFFFF combined with large offsets make the frame address wrap. The three spare addresses 5 to 7 can also be reached, so writes to them can be shown to have no effect. Random write sequences over all eight addresses cover every select transition and every mode combination. Directed steps cover the window before activation, the reserved select code and a second reset.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

  typedef struct packed {
    logic wrCtrl;
    logic wrPtr0;
    logic wrPtr1;
    logic wrBase;
    logic wrOffs;
  } dptrStrobe_t;

  typedef enum logic [1:0] {
    SEL_PTR0  = 2'b00,
    SEL_PTR1  = 2'b01,
    SEL_FRAME = 2'b10,
    SEL_RSVD  = 2'b11
  } srcSel_e;

  localparam int REG_CTRL = 0;
  localparam int REG_PTR0 = 1;
  localparam int REG_PTR1 = 2;
  localparam int REG_BASE = 3;
  localparam int REG_OFFS = 4;

  localparam int CTRL_FIELD_W = 5;
  localparam logic [CTRL_FIELD_W-1:0] CTRL_RESET = 5'b11100;

endpackage

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
  import dptr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [AW-1:0]     regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output dptrStrobe_t       stb,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [1:0]        srcIdx,
  output logic              srcWordMode,
  output logic              srcActive
);

  localparam int PAD_W = DATA_W - CTRL_FIELD_W;

  logic [2:0] wbsQ;
  srcSel_e    selQ;
  logic       activeQ;
  logic       anyWrite;

  // address decode into strobes
  always_comb begin
    stb = '0;
    if (regWrEn) begin
      stb.wrCtrl = (regAddr == AW'(REG_CTRL));
      stb.wrPtr0 = (regAddr == AW'(REG_PTR0));
      stb.wrPtr1 = (regAddr == AW'(REG_PTR1));
      stb.wrBase = (regAddr == AW'(REG_BASE));
      stb.wrOffs = (regAddr == AW'(REG_OFFS));
    end
  end

  assign anyWrite = |stb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbsQ    <= CTRL_RESET[4:2];
      selQ    <= srcSel_e'(CTRL_RESET[1:0]);
      activeQ <= 1'b0;
    end else begin
      if (stb.wrCtrl) begin
        wbsQ <= regWrData[4:2];
        selQ <= srcSel_e'(regWrData[1:0]);
      end else if (stb.wrPtr0) begin
        selQ <= SEL_PTR0;
      end else if (stb.wrPtr1) begin
        selQ <= SEL_PTR1;
      end else if (stb.wrBase || stb.wrOffs) begin
        selQ <= SEL_FRAME;
      end
      if (anyWrite) activeQ <= 1'b1;
    end
  end

  assign srcIdx      = (selQ == SEL_RSVD) ? 2'(SEL_FRAME) : 2'(selQ);
  assign srcWordMode = wbsQ[srcIdx];
  assign srcActive   = activeQ;
  assign ctrlWord    = {{PAD_W{1'b0}}, wbsQ, 2'(selQ)};

  assert_ptr0_sel_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrPtr0 && !stb.wrCtrl) |=> (srcIdx == 2'd0));
  assert_ptr1_sel_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrPtr1 && !stb.wrCtrl) |=> (srcIdx == 2'd1));
  assert_frame_sel_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrBase || stb.wrOffs) |=> (srcIdx == 2'd2));
  assert_mode_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (anyWrite && !stb.wrCtrl) |=> $stable(wbsQ));
  assert_active_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    srcActive |=> srcActive);
  assert_active_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!srcActive && !anyWrite) |=> !srcActive);
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    srcIdx != 2'd3);

endmodule

// File: rtl/dptr_regs.sv
module dptr_regs
  import dptr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 16,
  parameter int OFFS_W = 8,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dptrStrobe_t       stb,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [AW-1:0]     regAddr,
  input  logic [DATA_W-1:0] ctrlWord,
  input  logic [1:0]        srcIdx,
  output logic [DATA_W-1:0] regRdData,
  output logic [PTR_W-1:0]  srcAddr
);

  localparam int NUM_DP = 2;

  logic [PTR_W-1:0]  dpQ [NUM_DP];
  logic [PTR_W-1:0]  baseQ;
  logic [OFFS_W-1:0] offsQ;
  logic [PTR_W-1:0]  frameAddr;
  logic [NUM_DP-1:0] wrDp;

  assign wrDp = {stb.wrPtr1, stb.wrPtr0};

  for (genvar g = 0; g < NUM_DP; g++) begin : gDirect
    always_ff @(posedge clk) begin
      if (!rstN)        dpQ[g] <= '0;
      else if (wrDp[g]) dpQ[g] <= regWrData[PTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      offsQ <= '0;
    end else begin
      if (stb.wrBase) baseQ <= regWrData[PTR_W-1:0];
      if (stb.wrOffs) offsQ <= regWrData[OFFS_W-1:0];
    end
  end

  // wraps at PTR_W bits
  assign frameAddr = baseQ + PTR_W'(offsQ);

  always_comb begin
    unique case (srcIdx)
      2'd0:    srcAddr = dpQ[0];
      2'd1:    srcAddr = dpQ[1];
      default: srcAddr = frameAddr;
    endcase
  end

  always_comb begin
    case (regAddr)
      AW'(REG_CTRL): regRdData = ctrlWord;
      AW'(REG_PTR0): regRdData = DATA_W'(dpQ[0]);
      AW'(REG_PTR1): regRdData = DATA_W'(dpQ[1]);
      AW'(REG_BASE): regRdData = DATA_W'(baseQ);
      AW'(REG_OFFS): regRdData = DATA_W'(offsQ);
      default:       regRdData = '0;
    endcase
  end

  assert_ctrl_pad_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == AW'(REG_CTRL)) |-> (regRdData[DATA_W-1:CTRL_FIELD_W] == '0));
  assert_src_steady_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!(|stb)) |=> $stable(srcAddr));
  assert_offs_narrow_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == AW'(REG_OFFS)) |-> (regRdData[DATA_W-1:OFFS_W] == '0));

endmodule

// File: rtl/dptr_select_unit.sv
module dptr_select_unit
  import dptr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 16,
  parameter int OFFS_W = 8,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [AW-1:0]     regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              loadReq,
  output logic [1:0]        srcIdx,
  output logic [PTR_W-1:0]  srcAddr,
  output logic              srcWordMode,
  output logic              srcActive,
  output logic              loadErr
);

  dptrStrobe_t       stb;
  logic [DATA_W-1:0] ctrlWord;

  dptr_ctrl #(.DATA_W(DATA_W), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .stb(stb), .ctrlWord(ctrlWord),
    .srcIdx(srcIdx), .srcWordMode(srcWordMode), .srcActive(srcActive)
  );

  dptr_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W), .OFFS_W(OFFS_W), .AW(AW)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .regWrData(regWrData),
    .regAddr(regAddr), .ctrlWord(ctrlWord), .srcIdx(srcIdx),
    .regRdData(regRdData), .srcAddr(srcAddr)
  );

  assign loadErr = loadReq & ~srcActive;

  assert_no_err_when_active_R7: assert property (@(posedge clk) disable iff (!rstN)
    srcActive |-> !loadErr);
  assert_err_on_idle_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && !srcActive) |-> loadErr);

endmodule

// File: tb/dptr_select_unit_bench.sv
`timescale 1ns/100ps
module dptr_select_unit_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [2:0]  regAddr;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        loadReq;
  logic [1:0]  srcIdx;
  logic [15:0] srcAddr;
  logic        srcWordMode;
  logic        srcActive;
  logic        loadErr;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [2:0]  mWbs;
  logic [1:0]  mSel;
  logic        mAct;
  logic [15:0] mP0, mP1, mBase;
  logic [7:0]  mOffs;

  always #4 clk = ~clk;

  dptr_select_unit u_dptr_select_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .loadReq(loadReq),
    .srcIdx(srcIdx), .srcAddr(srcAddr), .srcWordMode(srcWordMode),
    .srcActive(srcActive), .loadErr(loadErr)
  );

  function automatic logic [1:0] expIdx();
    return (mSel == 2'b00) ? 2'd0 : (mSel == 2'b01) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [15:0] expAddr();
    case (expIdx())
      2'd0:    return mP0;
      2'd1:    return mP1;
      default: return mBase + {8'h00, mOffs};
    endcase
  endfunction

  function automatic logic [15:0] expRead(input int a);
    case (a)
      0: return {11'b0, mWbs, mSel};
      1: return mP0;
      2: return mP1;
      3: return mBase;
      4: return {8'h00, mOffs};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mWbs = 3'b111; mSel = 2'b00; mAct = 1'b0;
    mP0 = '0; mP1 = '0; mBase = '0; mOffs = '0;
  endtask

  task automatic modelWrite(input int a, input logic [15:0] d);
    case (a)
      0: begin mWbs = d[4:2]; mSel = d[1:0]; mAct = 1'b1; end
      1: begin mP0 = d; mSel = 2'b00; mAct = 1'b1; end
      2: begin mP1 = d; mSel = 2'b01; mAct = 1'b1; end
      3: begin mBase = d; mSel = 2'b10; mAct = 1'b1; end
      4: begin mOffs = d[7:0]; mSel = 2'b10; mAct = 1'b1; end
      default: ;
    endcase
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWrEn = 1'b0; loadReq = 1'b0; regAddr = '0; regWrData = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic doWrite(input int a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  // called just after a negedge: outputs are settled
  task automatic checkAll(input string tag);
    chk({tag, " R4 srcIdx"}, 32'(srcIdx), 32'(expIdx()));
    chk({tag, " R4 R8 srcAddr"}, 32'(srcAddr), 32'(expAddr()));
    chk({tag, " R3 srcWordMode"}, 32'(srcWordMode), 32'(mWbs[expIdx()]));
    chk({tag, " R6 srcActive"}, 32'(srcActive), 32'(mAct));
    loadReq = 1'b1; #0.2;
    chk({tag, " R7 loadErr"}, 32'(loadErr), 32'(!mAct));
    loadReq = 1'b0; #0.2;
    chk({tag, " R7 loadErr idle"}, 32'(loadErr), 32'd0);
    for (int a = 0; a < 8; a++) begin
      regAddr = 3'(a); #0.2;
      chk({tag, " R9 R10 R2 read"}, 32'(regRdData), 32'(expRead(a)));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0;
    doReset();
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl reset", 32'(expRead(0)), 32'h001C);
    checkAll("R1 reset");
    // R6 no activation while idle, R9 spare address write ignored
    doWrite(6, 16'hFFFF);
    checkAll("R9 R6 spare write");
    // R5 pointer 1 write selects it and activates
    doWrite(2, 16'h1234);
    checkAll("R5 ptr1 write");
    // R2 high bits ignored; R4 reserved code selects frame
    doWrite(0, 16'hFFE7);
    checkAll("R2 R4 reserved sel");
    // R8 wraparound, R10 offset narrow
    doWrite(3, 16'hFFF0);
    doWrite(4, 16'hABCD);
    checkAll("R8 R10 wrap");
    // R3 byte mode on frame only
    doWrite(0, 16'h000E);
    checkAll("R3 mode bits");
    // R5 ptr0 write
    doWrite(1, 16'h8001);
    checkAll("R5 ptr0 write");
    // R1 R6 second reset, then explicit select clear activates pointer 0
    doReset();
    @(negedge clk);
    checkAll("R1 second reset");
    doWrite(0, 16'h001C);
    checkAll("R6 explicit clear");
    // random phase
    for (int i = 0; i < 400; i++) begin
      int a;
      logic [15:0] d;
      a = int'($urandom_range(0, 7));
      d = 16'($urandom);
      if (($urandom % 4) == 0) d = {8'hFF, d[7:0]};
      doWrite(a, d);
      checkAll("random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule